// File: doc/BRIEF.md
# Two-Bank SDRAM Command Tracker

This block sits on the memory side of a two-bank SDRAM command bus. On every rising clock edge it samples the clock-enable level, the chip-select and the three strobe pins, the bank pin and the address pins. It compares the clock-enable level with the one it sampled one edge earlier. From these it classifies the command and decides whether the command is legal in the current state. Accepted commands update a small state record for each bank and for the device's power mode.

Each bank is idle, open, or busy with a burst that closes the bank by itself. The device is either running or in one of three low-power modes. A command that is not legal raises a one-cycle violation pulse and changes nothing. The block also reports the last opened row of each bank and the programmed mode word. It produces the data-mask controls: a write mask with no delay, and a read output-disable delayed by a fixed latency.

A bus monitor or memory model uses it to decode the command stream and flag protocol errors. It can also drive the array-side state machines of a behavioural SDRAM model.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: With clock enable high on this edge and the previous edge, the pins {ras_n,cas_n,we_n} decode as follows when cs_n is low: 000 mode set (code 1), 001 refresh (2), 011 activate (3), 101 read (4), 100 write (5), 110 burst stop (6), 010 precharge (7 with addr[10] low, 8 with addr[10] high). 111, or cs_n high, is no-op (0). The code appears on cmd_code and the bank pin on cmd_bank one edge later.
- R2: A mode set is accepted only while both banks are idle. It then stores {ba, addr} in mode_word. A mode set with an open bank raises violation and leaves mode_word unchanged.
- R3: For the one edge following an accepted mode set, any command other than no-op raises violation and is not carried out. Commands are accepted again from the second edge on.
- R4: ba low selects bank A and ba high selects bank B. An activate to an idle bank opens it and latches addr into that bank's row output. An activate to a bank that is not idle raises violation. bank_st shows bank A in bits [1:0] and bank B in [3:2], encoded as 0 idle, 1 open, 2 auto-closing burst.
- R5: A precharge with addr[10] low closes only the bank named by ba. With addr[10] high it closes both banks whatever ba is. Either form raises violation if a bank it would close is in an auto-closing burst.
- R6: A refresh with clock enable high on both edges is legal only with both banks idle. The same pattern with clock enable falling enters self refresh (code 9, pwr_st 3), but only with both banks idle. Clock enable rising afterwards reports exit (code 11) and returns pwr_st to 0.
- R7: A read or write to an open bank with addr[10] high starts an auto-closing burst. The burst length comes from mode_word[1:0]: 0, 1, 2 and 3 give 1, 2, 4 and 8. The bank shows state 2 for that many edges and then returns to idle. During the burst, a read, write, activate or precharge to the same bank raises violation. The other bank can still be used.
- R8: Clock enable falling with a no-op pattern, no burst running and no mode-set lockout enters power-down (code 10). pwr_st becomes 1 if both banks are idle, otherwise 2. Clock enable rising reports exit (code 11) and sets pwr_st to 0.
- R9: A read or write to an idle bank raises violation. So does any pattern other than no-op while clock enable is low on both edges, and any pattern other than no-op or refresh on a falling clock enable. A rejected command leaves bank states, rows and mode_word unchanged.
- R10: wr_mask follows dqm with no delay. rd_hiz equals dqm as sampled RD_DQM_LAT edges earlier.
- R11: A synchronous active-high reset makes every bank idle, clears mode_word, the rows, cmd_code and violation, and sets pwr_st to 0 with clock enable taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | ADDR_W | Address pins, bit AP_BIT is the auto-close/all-bank bit |
| dqm | input | 1 | Data mask pin |
| cmd_code | output | 4 | Classified command of the last edge |
| cmd_bank | output | 1 | Bank pin sampled with that command |
| violation | output | 1 | One-cycle pulse for an illegal command |
| bank_st | output | 4 | Per-bank state, two bits per bank |
| pwr_st | output | 2 | 0 running, 1 idle power-down, 2 open power-down, 3 self refresh |
| row_a | output | ADDR_W | Row latched by the last activate of bank A |
| row_b | output | ADDR_W | Row latched by the last activate of bank B |
| mode_word | output | ADDR_W+1 | Stored {ba, addr} of the last accepted mode set |
| wr_mask | output | 1 | Write data mask, same cycle |
| rd_hiz | output | 1 | Read output disable, delayed |

## Verification
The assertions assume that the pins are stable around each rising edge and that reset is held for at least one edge before any command. They also assume the read-mask latency stays small enough for a short history check. The bench changes inputs only on falling edges and begins every run under reset. It steps one command per edge through a table whose expected bank and power states follow the burst counts worked out from the stored mode word. The directed part then sets the shortest burst length and checks the other corner cases.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

   localparam int NBANK  = 2;
   localparam int MAX_BL = 8;
   localparam int CNT_W  = $clog2(MAX_BL + 1);

   typedef enum logic [3:0] {
      C_NOP   = 4'd0,
      C_MRS   = 4'd1,
      C_REF   = 4'd2,
      C_ACT   = 4'd3,
      C_RD    = 4'd4,
      C_WR    = 4'd5,
      C_BST   = 4'd6,
      C_PRE   = 4'd7,
      C_PREA  = 4'd8,
      C_SELF  = 4'd9,
      C_PDN   = 4'd10,
      C_EXIT  = 4'd11
   } cmd_e;

   typedef enum logic [1:0] {
      B_IDLE  = 2'd0,
      B_OPEN  = 2'd1,
      B_BURST = 2'd2
   } bank_e;

   typedef enum logic [1:0] {
      P_RUN   = 2'd0,
      P_PDIDL = 2'd1,
      P_PDOPN = 2'd2,
      P_SELF  = 2'd3
   } pwr_e;

endpackage

// File: rtl/sdr_pin_decode.sv
module sdr_pin_decode
   import sdr_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic ap,
   output cmd_e pat
);

   always_comb begin
      pat = C_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  pat = C_MRS;
            3'b001:  pat = C_REF;
            3'b011:  pat = C_ACT;
            3'b101:  pat = C_RD;
            3'b100:  pat = C_WR;
            3'b110:  pat = C_BST;
            3'b010:  pat = ap ? C_PREA : C_PRE;
            default: pat = C_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
   import sdr_cmd_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              act_i,
   input  logic              rwap_i,
   input  logic              pre_i,
   input  logic [CNT_W-1:0]  bl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output bank_e             st_o,
   output logic [ADDR_W-1:0] row_o
);

   bank_e             st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= B_IDLE;
         cnt_q <= '0;
         row_q <= '0;
      end else begin
         unique case (st_q)
            B_IDLE: begin
               if (act_i) begin
                  st_q  <= B_OPEN;
                  row_q <= addr_i;
               end
            end
            B_OPEN: begin
               if (rwap_i) begin
                  st_q  <= B_BURST;
                  cnt_q <= bl_i;
               end else if (pre_i) begin
                  st_q <= B_IDLE;
               end
            end
            B_BURST: begin
               if (cnt_q <= CNT_W'(1)) begin
                  st_q  <= B_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: st_q <= B_IDLE;
         endcase
      end
   end

   assign st_o  = st_q;
   assign row_o = row_q;

   // an auto-closing burst never falls back to the open state
   assert_burst_closes_R7: assert property (@(posedge clk) disable iff (rst)
      (st_q == B_BURST) |=> (st_q != B_OPEN));

   // a burst only starts from an open bank
   assert_burst_from_open_R7: assert property (@(posedge clk) disable iff (rst)
      (st_q == B_IDLE) |=> (st_q != B_BURST));

endmodule

// File: rtl/sdr_power_track.sv
module sdr_power_track
   import sdr_cmd_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic exit_i,
   input  logic self_i,
   input  logic pd_i,
   input  logic pd_open_i,
   output pwr_e st_o
);

   pwr_e st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= P_RUN;
      end else if (exit_i) begin
         st_q <= P_RUN;
      end else if (self_i) begin
         st_q <= P_SELF;
      end else if (pd_i) begin
         st_q <= pd_open_i ? P_PDOPN : P_PDIDL;
      end
   end

   assign st_o = st_q;

   assert_exit_runs_R8: assert property (@(posedge clk) disable iff (rst)
      exit_i |=> (st_q == P_RUN));

   assert_single_entry_R6: assert property (@(posedge clk) disable iff (rst)
      !(self_i && pd_i));

endmodule

// File: rtl/sdr_dqm_pipe.sv
module sdr_dqm_pipe #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic dqm,
   output logic wr_mask,
   output logic rd_hiz
);

   assign wr_mask = dqm;

   generate
      if (LAT == 0) begin : g_direct
         assign rd_hiz = dqm;
      end else begin : g_pipe
         localparam int SW = $clog2(LAT + 1);
         logic [LAT-1:0] sh_q;
         logic [SW-1:0]  since_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               sh_q    <= '0;
               since_q <= '0;
            end else begin
               sh_q <= {sh_q[LAT-1:0], dqm} >> 0;
               if (since_q != SW'(LAT)) since_q <= since_q + SW'(1);
            end
         end

         assign rd_hiz = sh_q[LAT-1];

         assert_rd_delay_R10: assert property (@(posedge clk) disable iff (rst)
            (since_q == SW'(LAT)) |-> (rd_hiz == $past(dqm, LAT)));
      end
   endgenerate

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
   import sdr_cmd_pkg::*;
#(
   parameter int ADDR_W     = 11,
   parameter int AP_BIT     = 10,
   parameter int MRS_GAP    = 2,
   parameter int RD_DQM_LAT = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              ba,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dqm,
   output logic [3:0]        cmd_code,
   output logic              cmd_bank,
   output logic              violation,
   output logic [3:0]        bank_st,
   output logic [1:0]        pwr_st,
   output logic [ADDR_W-1:0] row_a,
   output logic [ADDR_W-1:0] row_b,
   output logic [ADDR_W:0]   mode_word,
   output logic              wr_mask,
   output logic              rd_hiz
);

   localparam int MODE_W = ADDR_W + 1;
   localparam int LOCK_W = $clog2(MRS_GAP + 1);

   generate
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("AP_BIT must lie inside the address bus");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W too small for a mode word");
      end
      if (MRS_GAP < 1 || MRS_GAP > 15) begin : g_bad_gap
         $error("MRS_GAP out of range");
      end
      if (RD_DQM_LAT < 0 || RD_DQM_LAT > 4) begin : g_bad_lat
         $error("RD_DQM_LAT out of range");
      end
   endgenerate

   // ---------------- pin pattern ----------------
   cmd_e pat;

   sdr_pin_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .ap    (addr[AP_BIT]),
      .pat   (pat)
   );

   // ---------------- state registers ----------------
   logic              cke_q;
   logic [LOCK_W-1:0] lock_q;
   logic [MODE_W-1:0] mode_q;
   cmd_e              code_q;
   logic              bank_q;
   logic              viol_q;

   bank_e             st   [NBANK];
   logic [ADDR_W-1:0] rows [NBANK];
   pwr_e              pwr;

   logic both_idle, any_burst, any_open;
   always_comb begin
      both_idle = 1'b1;
      any_burst = 1'b0;
      any_open  = 1'b0;
      for (int i = 0; i < NBANK; i++) begin
         if (st[i] != B_IDLE)  both_idle = 1'b0;
         if (st[i] == B_BURST) any_burst = 1'b1;
         if (st[i] == B_OPEN)  any_open  = 1'b1;
      end
   end

   logic [CNT_W-1:0] bl_len;
   assign bl_len = CNT_W'(1) << mode_q[1:0];

   // ---------------- legality ----------------
   cmd_e             code_d;
   logic             viol_d, acc_mrs, go_self, go_pd, go_exit;
   logic [NBANK-1:0] do_act, do_rwap, do_pre;
   logic             locked;

   assign locked = (lock_q != '0);

   always_comb begin
      code_d  = pat;
      viol_d  = 1'b0;
      acc_mrs = 1'b0;
      go_self = 1'b0;
      go_pd   = 1'b0;
      go_exit = 1'b0;
      do_act  = '0;
      do_rwap = '0;
      do_pre  = '0;
      if (!cke_q && cke) begin
         code_d  = C_EXIT;
         go_exit = 1'b1;
      end else if (!cke_q && !cke) begin
         if (pat != C_NOP) viol_d = 1'b1;
      end else if (cke_q && !cke) begin
         if (pat == C_REF) begin
            code_d = C_SELF;
            if (both_idle && !locked) go_self = 1'b1;
            else                      viol_d  = 1'b1;
         end else if (pat == C_NOP) begin
            code_d = C_PDN;
            if (!any_burst && !locked) go_pd  = 1'b1;
            else                       viol_d = 1'b1;
         end else begin
            viol_d = 1'b1;
         end
      end else if (locked && pat != C_NOP) begin
         viol_d = 1'b1;
      end else begin
         unique case (pat)
            C_MRS: begin
               if (both_idle) acc_mrs = 1'b1;
               else           viol_d  = 1'b1;
            end
            C_REF: begin
               if (!both_idle) viol_d = 1'b1;
            end
            C_ACT: begin
               if (st[ba] == B_IDLE) do_act[ba] = 1'b1;
               else                  viol_d     = 1'b1;
            end
            C_RD, C_WR: begin
               if (st[ba] != B_OPEN)   viol_d      = 1'b1;
               else if (addr[AP_BIT])  do_rwap[ba] = 1'b1;
            end
            C_PRE: begin
               if (st[ba] == B_BURST) viol_d     = 1'b1;
               else                   do_pre[ba] = 1'b1;
            end
            C_PREA: begin
               if (any_burst) viol_d = 1'b1;
               else           do_pre = '1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cke_q  <= 1'b1;
         lock_q <= '0;
         mode_q <= '0;
         code_q <= C_NOP;
         bank_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         cke_q  <= cke;
         code_q <= code_d;
         bank_q <= ba;
         viol_q <= viol_d;
         if (acc_mrs) begin
            mode_q <= {ba, addr};
            lock_q <= LOCK_W'(MRS_GAP - 1);
         end else if (locked) begin
            lock_q <= lock_q - LOCK_W'(1);
         end
      end
   end

   // ---------------- per-bank trackers ----------------
   generate
      for (genvar g = 0; g < NBANK; g++) begin : g_bank
         sdr_bank_track #(.ADDR_W(ADDR_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .act_i  (do_act[g]),
            .rwap_i (do_rwap[g]),
            .pre_i  (do_pre[g]),
            .bl_i   (bl_len),
            .addr_i (addr),
            .st_o   (st[g]),
            .row_o  (rows[g])
         );
         assign bank_st[2*g +: 2] = st[g];
      end
   endgenerate

   sdr_power_track u_pwr (
      .clk       (clk),
      .rst       (rst),
      .exit_i    (go_exit),
      .self_i    (go_self),
      .pd_i      (go_pd),
      .pd_open_i (any_open),
      .st_o      (pwr)
   );

   sdr_dqm_pipe #(.LAT(RD_DQM_LAT)) u_dqm (
      .clk     (clk),
      .rst     (rst),
      .dqm     (dqm),
      .wr_mask (wr_mask),
      .rd_hiz  (rd_hiz)
   );

   assign cmd_code  = code_q;
   assign cmd_bank  = bank_q;
   assign violation = viol_q;
   assign pwr_st    = pwr;
   assign row_a     = rows[0];
   assign row_b     = rows[1];
   assign mode_word = mode_q;

   // ---------------- assertions ----------------
   assert_reject_keeps_mode_R9: assert property (@(posedge clk) disable iff (rst)
      viol_q |-> $stable(mode_q));

   assert_mode_only_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(mode_q) |-> $past(both_idle));

   assert_self_needs_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (pwr == P_SELF) |-> both_idle);

   assert_lowpower_no_burst_R8: assert property (@(posedge clk) disable iff (rst)
      (pwr != P_RUN) |-> !any_burst);

   assert_lock_blocks_R3: assert property (@(posedge clk) disable iff (rst)
      (locked && cke_q && cke && pat != C_NOP) |=> viol_q);

endmodule

// File: tb/sdr_cmd_tracker_test.sv
module sdr_cmd_tracker_test;

   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cke = 1'b1;
   logic          cs_n = 1'b1;
   logic          ras_n = 1'b1;
   logic          cas_n = 1'b1;
   logic          we_n = 1'b1;
   logic          ba = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          dqm = 1'b0;
   logic [3:0]    cmd_code;
   logic          cmd_bank;
   logic          violation;
   logic [3:0]    bank_st;
   logic [1:0]    pwr_st;
   logic [AW-1:0] row_a, row_b;
   logic [AW:0]   mode_word;
   logic          wr_mask, rd_hiz;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;   // 50 MHz

   sdr_cmd_tracker #(.ADDR_W(AW)) uut (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
      .cmd_code(cmd_code), .cmd_bank(cmd_bank), .violation(violation),
      .bank_st(bank_st), .pwr_st(pwr_st), .row_a(row_a), .row_b(row_b),
      .mode_word(mode_word), .wr_mask(wr_mask), .rd_hiz(rd_hiz)
   );

   typedef struct packed {
      logic       k;
      logic       cs;
      logic [2:0] rcw;
      logic       b;
      logic       ap;
      logic [3:0] code;
      logic       v;
      logic [3:0] bst;
      logic [1:0] pw;
   } vec_t;

   localparam int NV = 34;
   localparam vec_t TBL [NV] = '{
      '{1'b1,1'b0,3'b111,1'b0,1'b0,4'd0 ,1'b0,4'b0000,2'd0}, // R1 nop
      '{1'b1,1'b0,3'b000,1'b0,1'b0,4'd1 ,1'b0,4'b0000,2'd0}, // R2 mode set, BL 4
      '{1'b1,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b1,4'b0000,2'd0}, // R3 lockout edge
      '{1'b1,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b0,4'b0001,2'd0}, // R4 open A
      '{1'b1,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b1,4'b0001,2'd0}, // R4 reopen A
      '{1'b1,1'b0,3'b101,1'b1,1'b0,4'd4 ,1'b1,4'b0001,2'd0}, // R9 read idle B
      '{1'b1,1'b0,3'b011,1'b1,1'b0,4'd3 ,1'b0,4'b0101,2'd0}, // R4 open B
      '{1'b1,1'b0,3'b100,1'b0,1'b1,4'd5 ,1'b0,4'b0110,2'd0}, // R7 write A auto-close
      '{1'b1,1'b0,3'b101,1'b0,1'b0,4'd4 ,1'b1,4'b0110,2'd0}, // R7 same bank blocked
      '{1'b1,1'b0,3'b101,1'b1,1'b1,4'd4 ,1'b0,4'b1010,2'd0}, // R7 other bank allowed
      '{1'b1,1'b0,3'b001,1'b0,1'b0,4'd2 ,1'b1,4'b1010,2'd0}, // R6 refresh not idle
      '{1'b1,1'b1,3'b111,1'b0,1'b0,4'd0 ,1'b0,4'b1000,2'd0}, // R7 A closes after 4
      '{1'b1,1'b0,3'b010,1'b1,1'b0,4'd7 ,1'b1,4'b1000,2'd0}, // R5 precharge in burst
      '{1'b1,1'b0,3'b111,1'b0,1'b0,4'd0 ,1'b0,4'b0000,2'd0}, // R7 B closes
      '{1'b1,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b0,4'b0001,2'd0}, // R4
      '{1'b1,1'b0,3'b010,1'b1,1'b1,4'd8 ,1'b0,4'b0000,2'd0}, // R5 all banks, ba ignored
      '{1'b1,1'b0,3'b011,1'b1,1'b0,4'd3 ,1'b0,4'b0100,2'd0}, // R4
      '{1'b1,1'b0,3'b010,1'b1,1'b0,4'd7 ,1'b0,4'b0000,2'd0}, // R5 single bank
      '{1'b1,1'b0,3'b001,1'b0,1'b0,4'd2 ,1'b0,4'b0000,2'd0}, // R6 refresh idle
      '{1'b1,1'b0,3'b110,1'b0,1'b0,4'd6 ,1'b0,4'b0000,2'd0}, // R1 burst stop
      '{1'b0,1'b1,3'b111,1'b0,1'b0,4'd10,1'b0,4'b0000,2'd1}, // R8 idle power-down
      '{1'b0,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b1,4'b0000,2'd1}, // R9 command in power-down
      '{1'b1,1'b1,3'b111,1'b0,1'b0,4'd11,1'b0,4'b0000,2'd0}, // R8 exit
      '{1'b1,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b0,4'b0001,2'd0}, // R4
      '{1'b0,1'b1,3'b111,1'b0,1'b0,4'd10,1'b0,4'b0001,2'd2}, // R8 open power-down
      '{1'b1,1'b1,3'b111,1'b0,1'b0,4'd11,1'b0,4'b0001,2'd0}, // R8 exit
      '{1'b0,1'b0,3'b001,1'b0,1'b0,4'd9 ,1'b1,4'b0001,2'd0}, // R6 self refresh refused
      '{1'b1,1'b1,3'b111,1'b0,1'b0,4'd11,1'b0,4'b0001,2'd0}, // R6 exit
      '{1'b1,1'b0,3'b010,1'b0,1'b0,4'd7 ,1'b0,4'b0000,2'd0}, // R5
      '{1'b0,1'b0,3'b001,1'b0,1'b0,4'd9 ,1'b0,4'b0000,2'd3}, // R6 self refresh
      '{1'b0,1'b1,3'b111,1'b0,1'b0,4'd0 ,1'b0,4'b0000,2'd3}, // R6 hold
      '{1'b1,1'b1,3'b111,1'b0,1'b0,4'd11,1'b0,4'b0000,2'd0}, // R6 exit
      '{1'b1,1'b0,3'b011,1'b0,1'b0,4'd3 ,1'b0,4'b0001,2'd0}, // R4
      '{1'b1,1'b0,3'b100,1'b0,1'b0,4'd5 ,1'b0,4'b0001,2'd0}  // R1 plain write
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic issue(input logic k, input logic c, input logic [2:0] p,
                        input logic b, input logic [AW-1:0] a);
      cke = k; cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr = a;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      // R11 state under reset
      chk("R11 code", 32'(cmd_code), 0);
      chk("R11 bank", 32'(bank_st), 0);
      chk("R11 mode", 32'(mode_word), 0);
      chk("R11 pwr", 32'(pwr_st), 0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         issue(TBL[i].k, TBL[i].cs, TBL[i].rcw, TBL[i].b, {TBL[i].ap, 10'd2});
         chk("R1 code", 32'(cmd_code), 32'(TBL[i].code));
         chk("R9 violation", 32'(violation), 32'(TBL[i].v));
         chk("R4 bank state", 32'(bank_st), 32'(TBL[i].bst));
         chk("R8 power", 32'(pwr_st), 32'(TBL[i].pw));
      end

      chk("R2 mode word", 32'(mode_word), 32'h002);
      chk("R4 row A", 32'(row_a), 32'h002);

      issue(1'b1, 1'b0, 3'b011, 1'b1, 11'h155);
      chk("R4 row B", 32'(row_b), 32'h155);
      chk("R4 bank pin", 32'(cmd_bank), 1);
      chk("R4 both open", 32'(bank_st), 32'b0101);

      issue(1'b1, 1'b0, 3'b000, 1'b0, 11'h000);
      chk("R2 refused", 32'(violation), 1);
      chk("R2 mode kept", 32'(mode_word), 32'h002);

      issue(1'b1, 1'b0, 3'b010, 1'b0, 11'h400);
      chk("R5 all closed", 32'(bank_st), 0);
      chk("R9 row kept", 32'(row_b), 32'h155);

      issue(1'b1, 1'b0, 3'b000, 1'b0, 11'h000);
      chk("R2 accepted", 32'(violation), 0);
      chk("R2 new mode", 32'(mode_word), 0);
      issue(1'b1, 1'b1, 3'b111, 1'b0, 11'h000);
      issue(1'b1, 1'b0, 3'b011, 1'b0, 11'h000);
      chk("R3 accepted after gap", 32'(violation), 0);
      issue(1'b1, 1'b0, 3'b101, 1'b0, 11'h400);
      chk("R7 BL1 burst", 32'(bank_st), 32'b0010);
      issue(1'b1, 1'b1, 3'b111, 1'b0, 11'h000);
      chk("R7 BL1 closed", 32'(bank_st), 0);

      dqm = 1'b1;
      #1;
      chk("R10 write mask", 32'(wr_mask), 1);
      @(posedge clk);
      @(negedge clk);
      dqm = 1'b0;
      #1;
      chk("R10 write mask off", 32'(wr_mask), 0);
      chk("R10 read early", 32'(rd_hiz), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R10 read disable", 32'(rd_hiz), 1);
      @(posedge clk);
      @(negedge clk);
      chk("R10 read release", 32'(rd_hiz), 0);

      issue(1'b1, 1'b0, 3'b011, 1'b1, 11'h0aa);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R11 bank reset", 32'(bank_st), 0);
      chk("R11 row reset", 32'(row_b), 0);
      chk("R11 mode reset", 32'(mode_word), 0);
      chk("R11 viol reset", 32'(violation), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule